// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command interpreter on the device side of a byte-wide parallel NOR flash. Each bus write arrives as a one-cycle strobe that carries the full address and a data byte. The decoder follows the multi-write unlock protocol used by standard flash command sets. A three-write prefix opens program, security-ID program, lock and query commands. A six-write prefix opens the erase commands. When a sequence completes and is allowed, the decoder turns it into a single-cycle request to a separate operation sequencer. The request carries the latched address and data.

The decoder also keeps the query mode used for reads (array, identification, capability table or security-ID space). It tracks erase suspension and the lock state of the user security-ID region. It applies the write-protect input to a 64 KB boot block. A `busy` input from the sequencer marks an internal program or erase in progress. While it is high the decoder ignores every write except a suspend request. Requests that are refused are dropped with no indication.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `req_valid`, `query_mode`, `suspended` and `sid_locked` are all 0.
- R2: The writes low-address AAAh/AAh, 555h/55h and AAAh/A0h, followed by one more write, produce a program request: `req_kind`=1 with that write's address and data. It appears in the cycle after the write. Address bits above bit 11 are ignored during the unlock writes.
- R3: The writes AAAh/AAh, 555h/55h, AAAh/80h, AAAh/AAh and 555h/55h are followed by a final write. A final 50h at any address gives sector erase (`req_kind`=2). A final 30h gives block erase (`req_kind`=3). A final 10h gives chip erase (`req_kind`=4), but only when the final low address is AAAh. Any other final write issues nothing.
- R4: A write whose address or data does not match the expected next step of a sequence returns the decoder to its idle state. The remaining writes of that sequence then issue nothing, and a fresh sequence afterwards works normally.
- R5: After the three-write prefix, a final code of 90h, 98h or 88h sets `query_mode` to 1, 2 or 3 respectively. A final code of F0h sets it to 0. A single write of F0h from the idle state also sets it to 0.
- R6: While `busy` is 1, every write other than a suspend has no effect: no request is issued and the query mode is unchanged.
- R7: While `busy` is 1 after a sector or block erase, a write of B0h at any address issues suspend (`req_kind`=5) and sets `suspended`. B0h during a program does nothing. While the decoder is suspended and `busy` is 0, a single write of 30h issues resume (`req_kind`=6) and clears `suspended`. When the decoder is not suspended, 30h does nothing.
- R8: While suspended, a program request is issued only when the target lies outside the suspended region. The region is the 4 KB sector (address bits 20..12) for a sector erase, or the 64 KB block (bits 20..16) for a block erase. Erase requests are dropped while suspended.
- R9: When `wp_n` is 0, program, sector erase and block erase aimed at the boot block are dropped. The boot block is the block with bits 20..16 all ones (top variant, the default) or all zeros. Chip erase is dropped whenever `wp_n` is 0.
- R10: A prefix code of A5h followed by a write issues a security-ID program (`req_kind`=7) unless the region is locked. A prefix code of 85h followed by a write of 00h issues lock (`req_kind`=8) and sets `sid_locked`. Any other data after 85h does nothing. Once locked, the region stays locked until reset.
- R11: Every request is a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 21 | Write address |
| wr_data | input | 8 | Write data |
| wp_n | input | 1 | Write protect, active low |
| busy | input | 1 | Internal program or erase in progress |
| req_valid | output | 1 | Request pulse |
| req_kind | output | 4 | Request code (see R2, R3, R7, R10) |
| req_addr | output | 21 | Latched address of the request |
| req_data | output | 8 | Latched data of the request |
| query_mode | output | 2 | 0 array, 1 identification, 2 capability table, 3 security-ID |
| suspended | output | 1 | An erase is suspended |
| sid_locked | output | 1 | User security-ID region is locked |

## Verification
The hardest state to reach is a suspended erase with a program aimed just inside or just outside the suspended region. Reaching it takes a completed six-write erase, then `busy` raised by the bench acting as sequencer, then a suspend write, and then `busy` lowered. The bench walks that path for both a sector and a block erase. It places one program target in the same sector or block and one in the neighbour. Before these checks it sweeps a program over all 32 blocks with protection on and off, and it breaks the unlock prefix at each position.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_SID, SQ_LOCK, SQ_E3, SQ_E4, SQ_E5
  } seq_t;

  typedef enum logic [3:0] {
    EV_NONE, EV_PROG, EV_SECT, EV_BLK, EV_CHIP, EV_SIDPROG, EV_LOCK,
    EV_ID, EV_CFI, EV_SIDQ, EV_EXIT, EV_RESUME
  } ev_t;

  localparam logic [3:0] RK_PROG = 4'd1;
  localparam logic [3:0] RK_SECT = 4'd2;
  localparam logic [3:0] RK_BLK  = 4'd3;
  localparam logic [3:0] RK_CHIP = 4'd4;
  localparam logic [3:0] RK_SUSP = 4'd5;
  localparam logic [3:0] RK_RES  = 4'd6;
  localparam logic [3:0] RK_SIDP = 4'd7;
  localparam logic [3:0] RK_LOCK = 4'd8;

  localparam logic [1:0] MD_READ = 2'd0;
  localparam logic [1:0] MD_ID   = 2'd1;
  localparam logic [1:0] MD_CFI  = 2'd2;
  localparam logic [1:0] MD_SIDQ = 2'd3;

  localparam logic [11:0] LA_HI = 12'hAAA;
  localparam logic [11:0] LA_LO = 12'h555;

  localparam logic [7:0] CD_AA   = 8'hAA;
  localparam logic [7:0] CD_55   = 8'h55;
  localparam logic [7:0] CD_PROG = 8'hA0;
  localparam logic [7:0] CD_ERAS = 8'h80;
  localparam logic [7:0] CD_SIDP = 8'hA5;
  localparam logic [7:0] CD_LOCK = 8'h85;
  localparam logic [7:0] CD_ID   = 8'h90;
  localparam logic [7:0] CD_CFI  = 8'h98;
  localparam logic [7:0] CD_SIDQ = 8'h88;
  localparam logic [7:0] CD_EXIT = 8'hF0;
  localparam logic [7:0] CD_SECT = 8'h50;
  localparam logic [7:0] CD_BLK  = 8'h30;
  localparam logic [7:0] CD_CHIP = 8'h10;
  localparam logic [7:0] CD_SUSP = 8'hB0;
  localparam logic [7:0] CD_ZERO = 8'h00;

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int LOW_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [LOW_W-1:0]  lo,
  input  logic [DATA_W-1:0] d,
  output ev_t               ev
);

  localparam logic [LOW_W-1:0] K_HI = LOW_W'(LA_HI);
  localparam logic [LOW_W-1:0] K_LO = LOW_W'(LA_LO);

  seq_t st, nxt;
  logic at_hi, at_lo;

  assign at_hi = (lo == K_HI);
  assign at_lo = (lo == K_LO);

  always_comb begin
    nxt = st;
    ev  = EV_NONE;
    if (take) begin
      nxt = SQ_IDLE;
      case (st)
        SQ_IDLE: begin
          if (at_hi && d == DATA_W'(CD_AA)) nxt = SQ_U1;
          else if (d == DATA_W'(CD_EXIT))   ev  = EV_EXIT;
          else if (d == DATA_W'(CD_BLK))    ev  = EV_RESUME;
        end
        SQ_U1: if (at_lo && d == DATA_W'(CD_55)) nxt = SQ_U2;
        SQ_U2: begin
          if (at_hi) begin
            case (d)
              DATA_W'(CD_PROG): nxt = SQ_PROG;
              DATA_W'(CD_ERAS): nxt = SQ_E3;
              DATA_W'(CD_SIDP): nxt = SQ_SID;
              DATA_W'(CD_LOCK): nxt = SQ_LOCK;
              DATA_W'(CD_ID):   ev  = EV_ID;
              DATA_W'(CD_CFI):  ev  = EV_CFI;
              DATA_W'(CD_SIDQ): ev  = EV_SIDQ;
              DATA_W'(CD_EXIT): ev  = EV_EXIT;
              default:          ev  = EV_NONE;
            endcase
          end
        end
        SQ_PROG: ev = EV_PROG;
        SQ_SID:  ev = EV_SIDPROG;
        SQ_LOCK: if (d == DATA_W'(CD_ZERO)) ev = EV_LOCK;
        SQ_E3:   if (at_hi && d == DATA_W'(CD_AA)) nxt = SQ_E4;
        SQ_E4:   if (at_lo && d == DATA_W'(CD_55)) nxt = SQ_E5;
        SQ_E5: begin
          if (d == DATA_W'(CD_SECT))               ev = EV_SECT;
          else if (d == DATA_W'(CD_BLK))           ev = EV_BLK;
          else if (d == DATA_W'(CD_CHIP) && at_hi) ev = EV_CHIP;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= nxt;
  end

  // R4: a broken step never leaves the tracker deeper than the first unlock state
  a_r4_break_resets: assert property (@(posedge clk) disable iff (rst)
    (take && st == SQ_U1 && !(at_lo && d == DATA_W'(CD_55))) |=> (st == SQ_IDLE));

endmodule

// File: rtl/nor_region_chk.sv
module nor_region_chk #(
  parameter int ADDR_W   = 21,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-SECT_LSB-1:0] a_sect,
  input  logic [ADDR_W-SECT_LSB-1:0] s_sect,
  input  logic                       s_blk,
  output logic                       in_boot,
  output logic                       in_susp
);

  localparam int SW  = ADDR_W - SECT_LSB;
  localparam int BOF = BLK_LSB - SECT_LSB;

  logic [SW-BOF-1:0] a_blk;
  assign a_blk = a_sect[SW-1:BOF];

  generate
    if (TOP_BOOT) begin : g_top
      assign in_boot = &a_blk;
    end else begin : g_bottom
      assign in_boot = ~|a_blk;
    end
  endgenerate

  assign in_susp = s_blk ? (a_blk == s_sect[SW-1:BOF]) : (a_sect == s_sect);

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int LOW_W    = 12,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_n,
  input  logic              busy,
  output logic              req_valid,
  output logic [3:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        query_mode,
  output logic              suspended,
  output logic              sid_locked
);

  localparam int SW = ADDR_W - SECT_LSB;
  localparam int BW = ADDR_W - BLK_LSB;

  logic          take;
  ev_t           ev;
  logic          in_boot, in_susp, prot;
  logic          act_erase, act_blk;
  logic [SW-1:0] susp_sect;
  logic          susp_hit;
  logic          issue;
  logic [3:0]    kind;

  assign take = wr_valid && !busy;

  nor_seq_fsm #(.LOW_W(LOW_W), .DATA_W(DATA_W)) seq_i (
    .clk (clk),
    .rst (rst),
    .take(take),
    .lo  (wr_addr[LOW_W-1:0]),
    .d   (wr_data),
    .ev  (ev)
  );

  nor_region_chk #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB), .TOP_BOOT(TOP_BOOT)
  ) reg_i (
    .a_sect (wr_addr[ADDR_W-1:SECT_LSB]),
    .s_sect (susp_sect),
    .s_blk  (act_blk),
    .in_boot(in_boot),
    .in_susp(in_susp)
  );

  assign prot     = !wp_n && in_boot;
  assign susp_hit = wr_valid && busy && !suspended && act_erase &&
                    (wr_data == DATA_W'(CD_SUSP));

  always_comb begin
    issue = 1'b0;
    kind  = 4'd0;
    case (ev)
      EV_PROG:    if (!prot && !(suspended && in_susp)) begin issue = 1'b1; kind = RK_PROG; end
      EV_SECT:    if (!prot && !suspended) begin issue = 1'b1; kind = RK_SECT; end
      EV_BLK:     if (!prot && !suspended) begin issue = 1'b1; kind = RK_BLK; end
      EV_CHIP:    if (wp_n && !suspended) begin issue = 1'b1; kind = RK_CHIP; end
      EV_SIDPROG: if (!sid_locked) begin issue = 1'b1; kind = RK_SIDP; end
      EV_LOCK:    begin issue = 1'b1; kind = RK_LOCK; end
      EV_RESUME:  if (suspended) begin issue = 1'b1; kind = RK_RES; end
      default:    issue = 1'b0;
    endcase
    if (susp_hit) begin
      issue = 1'b1;
      kind  = RK_SUSP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_kind   <= 4'd0;
      req_addr   <= '0;
      req_data   <= '0;
      query_mode <= MD_READ;
      suspended  <= 1'b0;
      sid_locked <= 1'b0;
      act_erase  <= 1'b0;
      act_blk    <= 1'b0;
      susp_sect  <= '0;
    end else begin
      req_valid <= issue;
      if (issue) begin
        req_kind <= kind;
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
      case (ev)
        EV_ID:   query_mode <= MD_ID;
        EV_CFI:  query_mode <= MD_CFI;
        EV_SIDQ: query_mode <= MD_SIDQ;
        EV_EXIT: query_mode <= MD_READ;
        default: query_mode <= query_mode;
      endcase
      if (susp_hit) suspended <= 1'b1;
      else if (issue && kind == RK_RES) suspended <= 1'b0;
      if (issue && kind == RK_LOCK) sid_locked <= 1'b1;
      if (issue && !suspended) begin
        if (kind == RK_PROG || kind == RK_CHIP) begin
          act_erase <= 1'b0;
        end else if (kind == RK_SECT || kind == RK_BLK) begin
          act_erase <= 1'b1;
          act_blk   <= (kind == RK_BLK);
          susp_sect <= wr_addr[ADDR_W-1:SECT_LSB];
        end
      end
    end
  end

  logic [BW-1:0] req_blk;
  logic          req_boot;
  assign req_blk  = req_addr[ADDR_W-1:BLK_LSB];
  assign req_boot = TOP_BOOT ? (req_blk == {BW{1'b1}}) : (req_blk == {BW{1'b0}});

  // R6: busy blocks everything except a suspend write
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_valid && wr_data != DATA_W'(CD_SUSP)) |=> !req_valid);

  // R9: chip erase only with protection released
  a_r9_chip_wp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == RK_CHIP) |-> $past(wp_n));

  // R9: boot block writes only with protection released
  a_r9_boot_guard: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_boot &&
     (req_kind == RK_PROG || req_kind == RK_SECT || req_kind == RK_BLK)) |-> $past(wp_n));

  // R7: resume only out of a suspended state
  a_r7_resume_src: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == RK_RES) |-> (!suspended && $past(suspended)));

  // R7: suspend only while an operation was busy
  a_r7_suspend_src: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == RK_SUSP) |-> (suspended && $past(busy)));

  // R10: the lock is sticky
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    sid_locked |=> sid_locked);

endmodule

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [20:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wp_n;
  logic        busy;
  logic        req_valid;
  logic [3:0]  req_kind;
  logic [20:0] req_addr;
  logic [7:0]  req_data;
  logic [1:0]  query_mode;
  logic        suspended;
  logic        sid_locked;

  always #4 clk = ~clk;

  nor_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_n(wp_n), .busy(busy), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .query_mode(query_mode), .suspended(suspended), .sid_locked(sid_locked)
  );

  int nchk = 0;
  int nerr = 0;
  int n_req = 0;
  int dbl = 0;
  logic       prev_v = 1'b0;
  logic [3:0] l_kind;
  logic [20:0] l_addr;
  logic [7:0]  l_data;
  logic [8:0]  junk = 9'h05B;

  always @(negedge clk) begin
    if (req_valid) begin
      n_req++;
      l_kind = req_kind;
      l_addr = req_addr;
      l_data = req_data;
      if (prev_v) dbl++;
    end
    prev_v = req_valid;
  end

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic uw(input logic [11:0] lo, input logic [7:0] d);
    junk = junk + 9'd37;
    wr({junk, lo}, d);
  endtask

  task automatic pre3(input logic [7:0] code);
    uw(12'hAAA, 8'hAA); uw(12'h555, 8'h55); uw(12'hAAA, code);
  endtask

  task automatic prog(input logic [20:0] a, input logic [7:0] d);
    pre3(8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [20:0] a, input logic [7:0] code);
    pre3(8'h80); uw(12'hAAA, 8'hAA); uw(12'h555, 8'h55); wr(a, code);
  endtask

  task automatic expect_req(input bit want, input logic [3:0] k, input logic [20:0] a,
                            input logic [7:0] d, input string tag);
    bit ok;
    @(negedge clk); #1;
    nchk++;
    if (want) ok = (n_req == 1) && (l_kind == k) && (l_addr == a) && (l_data == d);
    else      ok = (n_req == 0);
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got count=%0d kind=%0d addr=%h data=%h, expected count=%0d kind=%0d addr=%h data=%h",
               tag, n_req, l_kind, l_addr, l_data, want ? 1 : 0, k, a, d);
    end
    n_req = 0;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    #1;
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #1200000;
    nchk++; nerr++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wp_n = 1'b1; busy = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_valid, 0, "R1 req_valid");
    chk(query_mode, 0, "R1 query_mode");
    chk(suspended, 0, "R1 suspended");
    chk(sid_locked, 0, "R1 sid_locked");

    // R2 program across all blocks, protection off
    for (int i = 0; i < 32; i++) begin
      prog({i[4:0], 16'h1234}, 8'(i * 7 + 1));
      expect_req(1, 4'd1, {i[4:0], 16'h1234}, 8'(i * 7 + 1), "R2 program sweep");
    end
    // R9 same sweep with protection on: top block dropped
    wp_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      prog({i[4:0], 16'h0F0F}, 8'h6C);
      expect_req(i != 31, 4'd1, {i[4:0], 16'h0F0F}, 8'h6C, "R9 protected program sweep");
    end
    erase6(21'h1F3000, 8'h50); expect_req(0, 4'd2, 0, 0, "R9 protected sector erase");
    erase6(21'h1F0000, 8'h30); expect_req(0, 4'd3, 0, 0, "R9 protected block erase");
    erase6(21'h0A5AAA, 8'h10); expect_req(0, 4'd4, 0, 0, "R9 chip erase with wp low");
    erase6(21'h1E3000, 8'h50); expect_req(1, 4'd2, 21'h1E3000, 8'h50, "R9 unprotected sector erase");
    wp_n = 1'b1;

    // R3 erase forms
    erase6(21'h0A5000, 8'h50); expect_req(1, 4'd2, 21'h0A5000, 8'h50, "R3 sector erase");
    erase6(21'h1F0000, 8'h30); expect_req(1, 4'd3, 21'h1F0000, 8'h30, "R3 block erase");
    erase6(21'h0A5AAA, 8'h10); expect_req(1, 4'd4, 21'h0A5AAA, 8'h10, "R3 chip erase");
    erase6(21'h0A5555, 8'h10); expect_req(0, 4'd4, 0, 0, "R3 chip erase wrong address");
    erase6(21'h0A5000, 8'h51); expect_req(0, 4'd2, 0, 0, "R3 unknown final code");

    // R4 break each step of the program prefix
    for (int p = 0; p < 4; p++) begin
      uw(p == 3 ? 12'hAAB : 12'hAAA, p == 0 ? 8'hAB : 8'hAA);
      uw(12'h555, p == 1 ? 8'h54 : 8'h55);
      uw(12'hAAA, p == 2 ? 8'hA1 : 8'hA0);
      wr(21'h012123, 8'h3C);
      expect_req(0, 4'd1, 0, 0, "R4 broken prefix");
    end
    prog(21'h012123, 8'h3C); expect_req(1, 4'd1, 21'h012123, 8'h3C, "R4 fresh sequence after break");

    // R5 query modes
    pre3(8'h90); chk(query_mode, 1, "R5 id entry");
    pre3(8'hF0); chk(query_mode, 0, "R5 three-write exit");
    pre3(8'h98); chk(query_mode, 2, "R5 cfi entry");
    wr(21'h133333, 8'hF0); chk(query_mode, 0, "R5 single exit");
    pre3(8'h88); chk(query_mode, 3, "R5 secid entry");
    wr(21'h000000, 8'hF0); chk(query_mode, 0, "R5 single exit 2");

    // R6 busy ignores writes
    pre3(8'h90);
    busy = 1'b1;
    wr(21'h000000, 8'hF0); chk(query_mode, 1, "R6 exit ignored while busy");
    prog(21'h020000, 8'h11); expect_req(0, 4'd1, 0, 0, "R6 program ignored while busy");
    busy = 1'b0;
    wr(21'h000000, 8'hF0); chk(query_mode, 0, "R6 exit after busy");

    // R7 suspend during program ignored
    prog(21'h040000, 8'h5A); expect_req(1, 4'd1, 21'h040000, 8'h5A, "R7 program before suspend try");
    busy = 1'b1;
    wr(21'h0ABCDE, 8'hB0); expect_req(0, 4'd5, 0, 0, "R7 suspend ignored on program");
    chk(suspended, 0, "R7 not suspended");
    busy = 1'b0;
    wr(21'h012345, 8'h30); expect_req(0, 4'd6, 0, 0, "R7 resume without suspend");

    // R7 R8 sector erase suspend
    erase6(21'h0A5000, 8'h50); expect_req(1, 4'd2, 21'h0A5000, 8'h50, "R7 sector erase start");
    busy = 1'b1;
    wr(21'h1F0F0F, 8'hB0); expect_req(1, 4'd5, 21'h1F0F0F, 8'hB0, "R7 suspend");
    chk(suspended, 1, "R7 suspended set");
    busy = 1'b0;
    prog(21'h0A5123, 8'h3C); expect_req(0, 4'd1, 0, 0, "R8 program inside suspended sector");
    prog(21'h0A6000, 8'h11); expect_req(1, 4'd1, 21'h0A6000, 8'h11, "R8 program in next sector");
    erase6(21'h100000, 8'h30); expect_req(0, 4'd3, 0, 0, "R8 erase while suspended");
    wr(21'h012345, 8'h30); expect_req(1, 4'd6, 21'h012345, 8'h30, "R7 resume");
    chk(suspended, 0, "R7 suspended cleared");

    // R8 block erase suspend
    erase6(21'h070000, 8'h30); expect_req(1, 4'd3, 21'h070000, 8'h30, "R8 block erase start");
    busy = 1'b1;
    wr(21'h000001, 8'hB0); expect_req(1, 4'd5, 21'h000001, 8'hB0, "R7 block suspend");
    busy = 1'b0;
    prog(21'h07F000, 8'h22); expect_req(0, 4'd1, 0, 0, "R8 program inside suspended block");
    prog(21'h080000, 8'h33); expect_req(1, 4'd1, 21'h080000, 8'h33, "R8 program in next block");
    wr(21'h1FFFFF, 8'h30); expect_req(1, 4'd6, 21'h1FFFFF, 8'h30, "R7 block resume");

    // R10 security-ID region
    pre3(8'hA5); wr(21'h000007, 8'h9E); expect_req(1, 4'd7, 21'h000007, 8'h9E, "R10 secid program");
    pre3(8'h85); wr(21'h000000, 8'h01); expect_req(0, 4'd8, 0, 0, "R10 lock wrong data");
    chk(sid_locked, 0, "R10 still unlocked");
    pre3(8'h85); wr(21'h000000, 8'h00); expect_req(1, 4'd8, 21'h000000, 8'h00, "R10 lock");
    chk(sid_locked, 1, "R10 locked");
    pre3(8'hA5); wr(21'h000003, 8'h44); expect_req(0, 4'd7, 0, 0, "R10 program after lock");

    // R11 pulse width
    chk(dbl, 0, "R11 single-cycle pulses");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule